// File: doc/BRIEF.md
# Write Unlock Gate

This block stands between the raw write request stream of a byte-wide nonvolatile memory and its page load engine. Writes are locked out by default. Each write session has to open with a fixed three-step key: data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA, then data 0xA0 to address 0x5555. The key writes are absorbed and never reach the page buffer. After the full key, the following writes go out to the page engine marked for commit. The gate locks again when the page engine signals that its programming cycle has finished.

A write that arrives while the gate is locked and does not match the expected key step is still sent on, but it is marked as a dummy. The page engine then runs a full busy period and stores nothing. The gate also holds back all writes for a programmable power-on delay after reset. It restarts the key when the gap between key steps is longer than the byte-load timeout.

Top module: `unlock_gate`

## Requirements
- R1: While reset is held, `outValid`, `gateOpen` and `powerReady` are 0.
- R2: `powerReady` rises at the PWR_DELAY-th rising clock edge after reset is released. A write sampled while `powerReady` is 0 gives no output and does not advance the key.
- R3: A write that matches the current key step (step one 0xAA at 0x5555, step two 0x55 at 0x2AAA, step three 0xA0 at 0x5555) gives no output. `gateOpen` goes to 1 on the clock edge that samples the third step.
- R4: While the gate is open, each write appears one cycle later on `outValid` with `outCommit`=1 and the same address and data. This includes writes to the key addresses.
- R5: The gate stays open until `progDone` is sampled after at least one committed write, and `gateOpen` is 0 from the next cycle. A write in the same cycle as that `progDone` is judged against key step one.
- R6: While the gate is locked, a write that does not match the current key step is emitted one cycle later with `outCommit`=0. The key then restarts at step one.
- R7: A key step, or the first write after the key, must arrive within GAP_LIMIT cycles of the previous key write, where back-to-back writes count as 1 cycle. If it does not, the key silently restarts at step one, or the open gate closes.
- R8: Matching covers all 15 address bits and all 8 data bits, so a single flipped bit in either makes a mismatch.
- R9: After a dummy write, every further write is dropped with no output until `progDone` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write request strobe, one cycle per write |
| wrAddr | input | 15 | Write request address |
| wrData | input | 8 | Write request data |
| progDone | input | 1 | Pulse from the page engine at the end of a programming cycle |
| outValid | output | 1 | Filtered write strobe to the page engine |
| outAddr | output | 15 | Filtered write address |
| outData | output | 8 | Filtered write data |
| outCommit | output | 1 | 1: store the byte; 0: dummy busy period only |
| gateOpen | output | 1 | Key accepted, writes pass as commits |
| powerReady | output | 1 | Power-on delay has elapsed |

## Verification
The bench builds the gate with PWR_DELAY=20 and GAP_LIMIT=8, in place of delays of millions and tens of thousands of cycles. This makes the exact edge where `powerReady` rises reachable, along with writes landing on both sides of the gap limit. Random gaps of up to GAP_LIMIT+2 idle cycles, mixed with key-biased writes and `progDone` pulses, cover expiry and relocking many times over. Directed cases hit the same-cycle `progDone` handover and single-bit mismatches.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int KEY_STEPS = 3;

  typedef enum logic [2:0] {
    ST_KEY0 = 3'd0,
    ST_KEY1 = 3'd1,
    ST_KEY2 = 3'd2,
    ST_OPEN = 3'd3,
    ST_LOAD = 3'd4,
    ST_HOLD = 3'd5
  } gateState_t;

  typedef struct packed {
    logic emit;
    logic commit;
  } gateStrobe_t;
endpackage

// File: rtl/unlock_gate_dp.sv
module unlock_gate_dp
  import gate_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [KEY_STEPS-1:0][ADDR_W-1:0] KEY_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [KEY_STEPS-1:0][DATA_W-1:0] KEY_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  gateStrobe_t          strobe,
  output logic [KEY_STEPS-1:0] keyHit,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic [DATA_W-1:0]    outData,
  output logic                 outCommit
);
  // one full-width comparator per key step
  for (genvar s = 0; s < KEY_STEPS; s++) begin : g_key
    assign keyHit[s] = (wrAddr == KEY_ADDR[s]) && (wrData == KEY_DATA[s]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outCommit <= 1'b0;
      outAddr   <= '0;
      outData   <= '0;
    end else begin
      outValid  <= strobe.emit;
      outCommit <= strobe.emit & strobe.commit;
      if (strobe.emit) begin
        outAddr <= wrAddr;
        outData <= wrData;
      end
    end
  end
endmodule

// File: rtl/unlock_gate_ctrl.sv
module unlock_gate_ctrl
  import gate_pkg::*;
#(
  parameter int PWR_DELAY = 1250000,
  parameter int GAP_LIMIT = 18750
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic                 progDone,
  input  logic [KEY_STEPS-1:0] keyHit,
  output gateStrobe_t          strobe,
  output logic                 gateOpen,
  output logic                 powerReady,
  output gateState_t           curState
);
  localparam int PWR_W = $clog2(PWR_DELAY + 1);
  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [PWR_W-1:0] PWR_LAST = PWR_W'(PWR_DELAY - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LIMIT - 1);

  gateState_t       state, effState, nextState;
  logic [PWR_W-1:0] pwrCnt;
  logic [GAP_W-1:0] gapCnt, nextGap;
  logic             stepHit;
  logic             timedState;

  // power-on hold-off counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt     <= '0;
      powerReady <= 1'b0;
    end else if (!powerReady) begin
      if (pwrCnt == PWR_LAST) powerReady <= 1'b1;
      else                    pwrCnt     <= pwrCnt + PWR_W'(1);
    end
  end

  // end of programming hands the current cycle back to key step one
  always_comb begin
    effState = state;
    if (progDone && (state == ST_LOAD || state == ST_HOLD)) effState = ST_KEY0;
  end

  always_comb begin
    case (effState)
      ST_KEY0: stepHit = keyHit[0];
      ST_KEY1: stepHit = keyHit[1];
      ST_KEY2: stepHit = keyHit[2];
      default: stepHit = 1'b0;
    endcase
  end

  assign timedState = (effState == ST_KEY1) || (effState == ST_KEY2) || (effState == ST_OPEN);

  always_comb begin
    nextState = effState;
    nextGap   = '0;
    strobe    = '0;
    if (!powerReady) begin
      nextState = state;
      nextGap   = gapCnt;
    end else if (wrValid) begin
      case (effState)
        ST_KEY0, ST_KEY1, ST_KEY2: begin
          if (stepHit) begin
            case (effState)
              ST_KEY0: nextState = ST_KEY1;
              ST_KEY1: nextState = ST_KEY2;
              default: nextState = ST_OPEN;
            endcase
          end else begin
            strobe.emit = 1'b1;
            nextState   = ST_HOLD;
          end
        end
        ST_OPEN, ST_LOAD: begin
          strobe.emit   = 1'b1;
          strobe.commit = 1'b1;
          nextState     = ST_LOAD;
        end
        default: nextState = effState;
      endcase
    end else if (timedState) begin
      if (gapCnt == GAP_LAST) nextState = ST_KEY0;
      else                    nextGap   = gapCnt + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_KEY0;
      gapCnt <= '0;
    end else begin
      state  <= nextState;
      gapCnt <= nextGap;
    end
  end

  assign gateOpen = (state == ST_OPEN) || (state == ST_LOAD);
  assign curState = state;
endmodule

// File: rtl/unlock_gate.sv
module unlock_gate
  import gate_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int PWR_DELAY = 1250000,
  parameter int GAP_LIMIT = 18750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progDone,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic              outCommit,
  output logic              gateOpen,
  output logic              powerReady
);
  gateStrobe_t          strobe;
  logic [KEY_STEPS-1:0] keyHit;
  gateState_t           curState;

  unlock_gate_ctrl #(.PWR_DELAY(PWR_DELAY), .GAP_LIMIT(GAP_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .progDone(progDone),
    .keyHit(keyHit), .strobe(strobe), .gateOpen(gateOpen),
    .powerReady(powerReady), .curState(curState)
  );

  unlock_gate_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .keyHit(keyHit), .outValid(outValid),
    .outAddr(outAddr), .outData(outData), .outCommit(outCommit)
  );
endmodule

// File: rtl/unlock_gate_chk.sv
module unlock_gate_chk
  import gate_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       progDone,
  input logic       outValid,
  input logic       outCommit,
  input logic       gateOpen,
  input logic       powerReady,
  input gateState_t curState
);
  a_r2_ready_before_out: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(powerReady));

  a_r3_key_write_silent: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> !outValid);

  a_r4_commit_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCommit) |-> $past(gateOpen));

  a_r5_relock_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (progDone && curState == ST_LOAD) |=> !gateOpen);

  a_r6_dummy_enters_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outCommit) |-> (curState == ST_HOLD));

  a_r9_hold_drops: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_HOLD && !progDone) |=> !outValid);
endmodule

bind unlock_gate unlock_gate_chk i_chk (
  .clk(clk), .rstN(rstN), .progDone(progDone), .outValid(outValid),
  .outCommit(outCommit), .gateOpen(gateOpen), .powerReady(powerReady),
  .curState(curState)
);

// File: tb/test_unlock_gate.sv
`timescale 1ns/1ps
module test_unlock_gate;
  localparam int PWR_DELAY = 20;
  localparam int GAP_LIMIT = 8;
  localparam int M_K0 = 0, M_K1 = 1, M_K2 = 2, M_OPEN = 3, M_LOAD = 4, M_HOLD = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        progDone = 1'b0;
  logic        outValid, outCommit, gateOpen, powerReady;
  logic [14:0] outAddr;
  logic [7:0]  outData;

  int checks = 0;
  int errors = 0;
  int ms = M_K0;
  int gap = 0;
  int edges = 0;

  always #4 clk = ~clk;

  unlock_gate #(.PWR_DELAY(PWR_DELAY), .GAP_LIMIT(GAP_LIMIT)) i_unlock_gate (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .progDone(progDone), .outValid(outValid), .outAddr(outAddr), .outData(outData),
    .outCommit(outCommit), .gateOpen(gateOpen), .powerReady(powerReady)
  );

  function automatic logic [14:0] keyAddr(int s);
    return (s == 1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] keyData(int s);
    return (s == 0) ? 8'hAA : (s == 1) ? 8'h55 : 8'hA0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, update the model, sample at the next falling edge
  task automatic runCycle(logic w, logic [14:0] a, logic [7:0] d, logic dn, string req);
    logic eV, eC;
    string tag;
    wrValid = w; wrAddr = a; wrData = d; progDone = dn;
    @(posedge clk);
    @(negedge clk);
    edges++;
    eV = 1'b0; eC = 1'b0; tag = "R5";
    if (edges - 1 < PWR_DELAY) begin
      tag = "R2";
    end else begin
      if (dn && (ms == M_LOAD || ms == M_HOLD)) ms = M_K0;
      if (w) begin
        if (ms <= M_K2) begin
          gap = 0;
          if (a == keyAddr(ms) && d == keyData(ms)) begin
            ms = ms + 1; tag = "R3";
          end else begin
            eV = 1'b1; ms = M_HOLD; tag = "R6";
          end
        end else if (ms == M_OPEN || ms == M_LOAD) begin
          eV = 1'b1; eC = 1'b1; ms = M_LOAD; gap = 0; tag = "R4";
        end else begin
          tag = "R9";
        end
      end else if (ms == M_K1 || ms == M_K2 || ms == M_OPEN) begin
        if (gap == GAP_LIMIT - 1) begin
          ms = M_K0; gap = 0; tag = "R7";
        end else gap++;
      end else gap = 0;
    end
    if (req != "") tag = req;
    wrValid = 1'b0; progDone = 1'b0;
    check(tag, "outValid", 32'(outValid), 32'(eV));
    if (eV) begin
      check(tag, "outCommit", 32'(outCommit), 32'(eC));
      check(tag, "outAddr", 32'(outAddr), 32'(a));
      check(tag, "outData", 32'(outData), 32'(d));
    end
    check("R5", "gateOpen", 32'(gateOpen), 32'(ms == M_OPEN || ms == M_LOAD));
    check("R2", "powerReady", 32'(powerReady), 32'(edges >= PWR_DELAY));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) runCycle(1'b0, '0, '0, 1'b0, "");
  endtask

  task automatic sendKey(string req);
    for (int s = 0; s < 3; s++) runCycle(1'b1, keyAddr(s), keyData(s), 1'b0, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "outValid", 32'(outValid), 32'd0);
    check("R1", "gateOpen", 32'(gateOpen), 32'd0);
    check("R1", "powerReady", 32'(powerReady), 32'd0);
    rstN = 1'b1;
    // R2: key during power-on hold-off is ignored
    sendKey("R2");
    runCycle(1'b1, 15'h0100, 8'h12, 1'b0, "R2");
    idle(PWR_DELAY - 6);
    // edges now PWR_DELAY-2; cross the ready edge
    idle(2);
    // R4: key then data, including key address as data
    sendKey("R3");
    runCycle(1'b1, 15'h0040, 8'h3C, 1'b0, "R4");
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b0, "R4");
    runCycle(1'b1, 15'h0041, 8'hC3, 1'b0, "R4");
    idle(3);
    // R5: write in the progDone cycle is judged as key step one
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b1, "R5");
    runCycle(1'b1, 15'h2AAA, 8'h55, 1'b0, "R5");
    runCycle(1'b1, 15'h5555, 8'hA0, 1'b0, "R5");
    runCycle(1'b1, 15'h1234, 8'h77, 1'b0, "R4");
    runCycle(1'b0, '0, '0, 1'b1, "R5");
    // R8: one address bit off at step two
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b0, "R3");
    runCycle(1'b1, 15'h2AAB, 8'h55, 1'b0, "R8");
    // R9: writes during the dummy busy period are dropped
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b0, "R9");
    runCycle(1'b1, 15'h0001, 8'h01, 1'b0, "R9");
    runCycle(1'b0, '0, '0, 1'b1, "R9");
    // R8: one data bit off at step three
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b0, "R3");
    runCycle(1'b1, 15'h2AAA, 8'h55, 1'b0, "R3");
    runCycle(1'b1, 15'h5555, 8'hA1, 1'b0, "R8");
    runCycle(1'b0, '0, '0, 1'b1, "R9");
    // R7: gap exactly at the limit passes, one more cycle expires
    runCycle(1'b1, 15'h5555, 8'hAA, 1'b0, "R3");
    idle(GAP_LIMIT - 1);
    runCycle(1'b1, 15'h2AAA, 8'h55, 1'b0, "R7");
    idle(GAP_LIMIT);
    runCycle(1'b1, 15'h5555, 8'hA0, 1'b0, "R7");
    runCycle(1'b0, '0, '0, 1'b1, "R7");
    // R7: open gate with no data write closes after the gap limit
    sendKey("R3");
    idle(GAP_LIMIT);
    runCycle(1'b1, 15'h0200, 8'h5A, 1'b0, "R7");
    runCycle(1'b0, '0, '0, 1'b1, "R6");
    // R6: plain write without key
    runCycle(1'b1, 15'h0300, 8'h99, 1'b0, "R6");
    runCycle(1'b0, '0, '0, 1'b1, "R6");
    // random phase
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 35 && ms <= M_K2) begin
        runCycle(1'b1, keyAddr(ms), keyData(ms), ($urandom % 8) == 0, "");
      end else if (r < 55) begin
        runCycle(1'b1, ($urandom % 4 == 0) ? 15'h5555 : 15'($urandom),
                 8'($urandom), ($urandom % 8) == 0, "");
      end else if (r < 63) begin
        runCycle(1'b0, '0, '0, 1'b1, "");
      end else begin
        idle(int'($urandom % (GAP_LIMIT + 3)));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule